// File: doc/BRIEF.md
# Configurable Interrupt Trigger Detector

This block holds one request flag per interrupt source and decides, per source, which condition on the raw request line raises that flag. Every raw line passes through a two-stage synchronizer. A history register then keeps the previous synchronized value so that transitions can be seen. Each source uses one of four sense modes: active-low level, falling edge, rising edge or any edge.

How a flag is cleared depends on its mode. A level source follows its line: the flag drops as soon as the line returns high. An edge source keeps its flag until software writes zero to it or until the source is acknowledged. A small register port gives access to each flag. It also gives access to the mode field of the external-pin sources, the only sources whose mode software can change. All other sources keep the mode chosen by parameters at build time.

Besides the flag vector, the block gives a one-cycle pulse for every source that has just had a new request issued. Arbitration, masking and vectoring are left to the logic downstream.

Top module: `irq_trig_bank`

## Requirements
- R1: After reset all flags and issue pulses are 0. Every source is in rising-edge mode (code 2), except the sources named in the level-index parameter list, which are in level mode (code 0). The default list is sources 8 and 9.
- R2: In rising-edge mode a 0-to-1 change of the raw line sets the flag and pulses issue for exactly one cycle, three clock edges after the line changes. A 1-to-0 change in this mode does nothing.
- R3: In falling-edge mode (code 1) only a 1-to-0 change sets the flag. In both-edges mode (code 3) either change sets it.
- R4: In level mode (code 0) the flag is 1 while the synchronized line is low and returns to 0 as soon as the line is high. Issue pulses once when the flag goes from 0 to 1.
- R5: A register write with reg_sel=0 and wdata bit 0 equal to 0 clears the addressed flag if that source is in an edge mode. Writing 1 has no effect. Level-mode flags are never changed by a write.
- R6: An ack_valid pulse carrying ack_id clears that source's flag if the source is in an edge mode. A level-mode flag stays set.
- R7: Pin sources PIN_BASE to PIN_BASE+N_PINS-1 (64 to 79 by default) have a writable mode held in bits [3:2] of their control register (reg_sel=1). A read returns the mode in bits [3:2] and zeros elsewhere. A control write to any other address is ignored, and a control read of any other address returns 0.
- R8: When a new edge event and a clear (write or ack) reach the same source on the same clock edge, the event wins and the flag ends at 1.
- R9: A flag read (reg_sel=0) returns the addressed flag in bit 0 and zeros in the other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| raw_irq | input | N_SRC | Raw asynchronous request lines, idle high |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects a flag register, 1 selects a pin control register |
| reg_addr | input | IDX_W | Source index addressed |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for reg_sel/reg_addr |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_id | input | IDX_W | Source being acknowledged |
| flag | output | N_SRC | Request flag vector |
| issue | output | N_SRC | One-cycle pulse per newly issued request |

## Verification
The checker watches every source on every cycle. It checks that each detected edge event sets the flag on the next edge, and that a level-mode flag equals the inverse of the synchronized line one cycle earlier. It also checks that a flag can only rise together with an issue pulse, and that a clear with no competing event leaves an edge flag at 0. The effect of each mode on real input sequences needs the bench's scenarios: the three-edge latency through the synchronizer, software changes of a pin's mode, writes that must be ignored, and a clear colliding with an event.

// File: rtl/irq_trig_pkg.sv
package irq_trig_pkg;
  typedef enum logic [1:0] {
    SNS_LOW  = 2'd0,
    SNS_FALL = 2'd1,
    SNS_RISE = 2'd2,
    SNS_BOTH = 2'd3
  } sense_e;

  // Transition detector for the three edge modes.
  function automatic logic edge_hit(logic [1:0] mode, logic prev, logic cur);
    case (mode)
      SNS_FALL: edge_hit = prev & ~cur;
      SNS_RISE: edge_hit = ~prev & cur;
      SNS_BOTH: edge_hit = prev ^ cur;
      default:  edge_hit = 1'b0;
    endcase
  endfunction

  function automatic logic is_level(logic [1:0] mode);
    is_level = (mode == SNS_LOW);
  endfunction
endpackage

// File: rtl/irq_line_sync.sv
module irq_line_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] meta_q, cur_q, hist_q;

  // Idle level of the lines is high; reset to it so no edge is invented.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      cur_q  <= '1;
      hist_q <= '1;
    end else begin
      meta_q <= raw;
      cur_q  <= meta_q;
      hist_q <= cur_q;
    end
  end

  assign cur  = cur_q;
  assign prev = hist_q;
endmodule

// File: rtl/irq_pin_sense.sv
module irq_pin_sense #(
  parameter int unsigned N_PINS = 16,
  parameter logic [2*N_PINS-1:0] RST_MODES = '0,
  localparam int unsigned PIN_W = (N_PINS > 1) ? $clog2(N_PINS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [PIN_W-1:0]         wr_idx,
  input  logic [1:0]               wr_mode,
  output logic [N_PINS-1:0][1:0]   modes
);
  logic [N_PINS-1:0][1:0] mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= RST_MODES;
    end else if (wr_en) begin
      mode_q[wr_idx] <= wr_mode;
    end
  end

  assign modes = mode_q;
endmodule

// File: rtl/irq_src_cell.sv
module irq_src_cell
  import irq_trig_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       cur,
  input  logic       prev,
  input  logic       clr_sw,
  input  logic       clr_ack,
  output logic       hit,
  output logic       flag,
  output logic       issue
);
  logic flag_q, flag_d, issue_q, issue_d;

  assign hit = edge_hit(mode, prev, cur);

  always_comb begin
    flag_d  = flag_q;
    issue_d = 1'b0;
    if (is_level(mode)) begin
      flag_d  = ~cur;
      issue_d = ~cur & ~flag_q;
    end else if (hit) begin
      flag_d  = 1'b1;               // new event beats a clear
      issue_d = 1'b1;
    end else if (clr_sw || clr_ack) begin
      flag_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      issue_q <= 1'b0;
    end else begin
      flag_q  <= flag_d;
      issue_q <= issue_d;
    end
  end

  assign flag  = flag_q;
  assign issue = issue_q;
endmodule

// File: rtl/irq_trig_bank.sv
module irq_trig_bank
  import irq_trig_pkg::*;
#(
  parameter int unsigned N_SRC    = 256,
  parameter int unsigned PIN_BASE = 64,
  parameter int unsigned N_PINS   = 16,
  parameter int unsigned LVL_CNT  = 2,
  parameter int unsigned LVL_IDX [LVL_CNT] = '{8, 9},
  localparam int unsigned IDX_W    = $clog2(N_SRC),
  localparam int unsigned PIN_W    = (N_PINS > 1) ? $clog2(N_PINS) : 1,
  localparam int unsigned MODE_LSB = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] raw_irq,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [IDX_W-1:0] reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             ack_valid,
  input  logic [IDX_W-1:0] ack_id,
  output logic [N_SRC-1:0] flag,
  output logic [N_SRC-1:0] issue
);
  function automatic logic [N_SRC-1:0][1:0] build_rst_modes();
    logic [N_SRC-1:0][1:0] m;
    for (int i = 0; i < N_SRC; i++) m[i] = SNS_RISE;
    for (int k = 0; k < LVL_CNT; k++) m[LVL_IDX[k]] = SNS_LOW;
    return m;
  endfunction

  localparam logic [N_SRC-1:0][1:0] RST_MODES = build_rst_modes();

  function automatic logic [2*N_PINS-1:0] pin_rst_modes();
    logic [2*N_PINS-1:0] v;
    for (int p = 0; p < N_PINS; p++) v[2*p +: 2] = RST_MODES[PIN_BASE + p];
    return v;
  endfunction

  // Events brought out as named wires for the checker.
  logic [N_SRC-1:0]      cur_vec, prev_vec;
  logic [N_SRC-1:0]      evt_hit, sw_clr, ack_clr;
  logic [N_SRC-1:0][1:0] mode_vec;
  logic [N_PINS-1:0][1:0] pin_mode;

  logic             pin_hit;
  logic [PIN_W-1:0] pin_idx;
  logic             pin_wr;

  assign pin_hit = (int'(reg_addr) >= PIN_BASE) && (int'(reg_addr) < PIN_BASE + N_PINS);
  assign pin_idx = PIN_W'(int'(reg_addr) - PIN_BASE);
  assign pin_wr  = reg_wr && reg_sel && pin_hit;

  irq_line_sync #(.W(N_SRC)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .raw  (raw_irq),
    .cur  (cur_vec),
    .prev (prev_vec)
  );

  irq_pin_sense #(.N_PINS(N_PINS), .RST_MODES(pin_rst_modes())) u_pins (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (pin_wr),
    .wr_idx (pin_idx),
    .wr_mode(reg_wdata[MODE_LSB +: 2]),
    .modes  (pin_mode)
  );

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    if (i >= PIN_BASE && i < PIN_BASE + N_PINS) begin : g_pin
      assign mode_vec[i] = pin_mode[i - PIN_BASE];
    end else begin : g_fixed
      assign mode_vec[i] = RST_MODES[i];
    end

    assign sw_clr[i]  = reg_wr && !reg_sel && (int'(reg_addr) == i) && !reg_wdata[0];
    assign ack_clr[i] = ack_valid && (int'(ack_id) == i);

    irq_src_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .mode   (mode_vec[i]),
      .cur    (cur_vec[i]),
      .prev   (prev_vec[i]),
      .clr_sw (sw_clr[i]),
      .clr_ack(ack_clr[i]),
      .hit    (evt_hit[i]),
      .flag   (flag[i]),
      .issue  (issue[i])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (!reg_sel) begin
      reg_rdata[0] = flag[reg_addr];
    end else if (pin_hit) begin
      reg_rdata[MODE_LSB +: 2] = pin_mode[pin_idx];
    end
  end
endmodule

// File: rtl/irq_trig_bank_chk.sv
module irq_trig_bank_chk #(
  parameter int unsigned N_SRC = 256
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [N_SRC-1:0]      flag,
  input logic [N_SRC-1:0]      issue,
  input logic [N_SRC-1:0]      evt_hit,
  input logic [N_SRC-1:0]      sw_clr,
  input logic [N_SRC-1:0]      ack_clr,
  input logic [N_SRC-1:0][1:0] mode_vec,
  input logic [N_SRC-1:0]      cur_vec
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_chk
    // R2 / R3: a detected edge sets the flag and pulses issue next cycle
    a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
      evt_hit[i] && (mode_vec[i] != 2'd0) |=> flag[i] && issue[i]);

    // R4: level flag equals inverted synchronized line one cycle earlier
    a_r4_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_vec[i] == 2'd0) |=> (flag[i] == !$past(cur_vec[i])));

    // R5 / R6: a clear with no competing event leaves an edge flag low
    a_r6_clear_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_clr[i] || ack_clr[i]) && !evt_hit[i] && (mode_vec[i] != 2'd0) |=> !flag[i]);

    // R8: event wins over a simultaneous clear
    a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_clr[i] || ack_clr[i]) && evt_hit[i] && (mode_vec[i] != 2'd0) |=> flag[i]);

    // R4 / R2: a flag only rises together with an issue pulse
    a_r2_rise_has_issue: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag[i]) |-> issue[i]);

    // R2: issue never stands alone without the flag
    a_r2_issue_flag: assert property (@(posedge clk) disable iff (!rst_n)
      issue[i] |-> flag[i]);
  end
endmodule

bind irq_trig_bank irq_trig_bank_chk #(.N_SRC(N_SRC)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .flag    (flag),
  .issue   (issue),
  .evt_hit (evt_hit),
  .sw_clr  (sw_clr),
  .ack_clr (ack_clr),
  .mode_vec(mode_vec),
  .cur_vec (cur_vec)
);

// File: tb/irq_trig_bank_tb.sv
module irq_trig_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 256;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  raw_irq = '1;
  logic          reg_wr = 1'b0;
  logic          reg_sel = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [7:0]    reg_wdata = '0;
  logic [7:0]    reg_rdata;
  logic          ack_valid = 1'b0;
  logic [AW-1:0] ack_id = '0;
  logic [N-1:0]  flag, issue;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_trig_bank u_dut (
    .clk(clk), .rst_n(rst_n), .raw_irq(raw_irq),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ack_valid(ack_valid), .ack_id(ack_id),
    .flag(flag), .issue(issue)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic sel, input int addr, input logic [7:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_addr = AW'(addr); reg_wdata = d;
    cyc(1);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic sel, input int addr, output logic [7:0] d);
    reg_sel = sel; reg_addr = AW'(addr);
    #1 d = reg_rdata;
  endtask

  task automatic ack(input int id);
    ack_valid = 1'b1; ack_id = AW'(id);
    cyc(1);
    ack_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 flags after reset", 32'(|flag), 0);
    chk("R1 issue after reset", 32'(|issue), 0);
    rd_reg(1'b1, 64, d);
    chk("R1 pin 64 default rising", d, 8'h08);
    raw_irq[9] = 1'b0; cyc(3);
    chk("R1 source 9 is level", flag[9], 1);
    raw_irq[9] = 1'b1; cyc(3);
    chk("R1 source 9 clears on high", flag[9], 0);
  endtask

  task automatic t_rise();
    raw_irq[3] = 1'b0; cyc(3);
    chk("R2 falling ignored in rise mode", flag[3], 0);
    raw_irq[3] = 1'b1; cyc(2);
    chk("R2 not set after two edges", flag[3], 0);
    cyc(1);
    chk("R2 flag set on third edge", flag[3], 1);
    chk("R2 issue pulse", issue[3], 1);
    cyc(1);
    chk("R2 issue one cycle", issue[3], 0);
    chk("R2 flag held", flag[3], 1);
  endtask

  task automatic t_read_and_clear();
    logic [7:0] d;
    rd_reg(1'b0, 3, d);
    chk("R9 flag read", d, 8'h01);
    wr_reg(1'b0, 3, 8'hFF);
    chk("R5 write 1 no effect", flag[3], 1);
    wr_reg(1'b0, 3, 8'hFE);
    chk("R5 write 0 clears edge flag", flag[3], 0);
    rd_reg(1'b0, 3, d);
    chk("R9 cleared flag read", d, 8'h00);
  endtask

  task automatic t_level();
    raw_irq[8] = 1'b0; cyc(3);
    chk("R4 level set", flag[8], 1);
    chk("R4 level issue", issue[8], 1);
    cyc(2);
    chk("R4 no repeat issue", issue[8], 0);
    wr_reg(1'b0, 8, 8'h00);
    chk("R5 write ignored on level", flag[8], 1);
    ack(8);
    chk("R6 ack keeps level flag", flag[8], 1);
    raw_irq[8] = 1'b1; cyc(3);
    chk("R4 level clears on high", flag[8], 0);
  endtask

  task automatic t_ack();
    raw_irq[6] = 1'b0; cyc(3);
    raw_irq[6] = 1'b1; cyc(3);
    chk("R6 precondition flag", flag[6], 1);
    ack(5);
    chk("R6 other id untouched", flag[6], 1);
    ack(6);
    chk("R6 ack clears edge flag", flag[6], 0);
  endtask

  task automatic t_pin_modes();
    logic [7:0] d;
    wr_reg(1'b1, 64, 8'h04);
    rd_reg(1'b1, 64, d);
    chk("R7 mode readback falling", d, 8'h04);
    raw_irq[64] = 1'b0; cyc(3);
    chk("R3 falling sets", flag[64], 1);
    wr_reg(1'b0, 64, 8'h00);
    raw_irq[64] = 1'b1; cyc(3);
    chk("R3 rising ignored in fall mode", flag[64], 0);
    wr_reg(1'b1, 64, 8'h0C);
    raw_irq[64] = 1'b0; cyc(3);
    chk("R3 both-edges on fall", flag[64], 1);
    wr_reg(1'b0, 64, 8'h00);
    raw_irq[64] = 1'b1; cyc(3);
    chk("R3 both-edges on rise", flag[64], 1);
    wr_reg(1'b0, 64, 8'h00);
    wr_reg(1'b1, 65, 8'hF3);
    rd_reg(1'b1, 65, d);
    chk("R7 only bits 3:2 kept", d, 8'h00);
    raw_irq[65] = 1'b0; cyc(3);
    chk("R7 pin switched to level", flag[65], 1);
    raw_irq[65] = 1'b1; cyc(3);
    chk("R7 level pin clears", flag[65], 0);
    wr_reg(1'b1, 3, 8'h04);
    rd_reg(1'b1, 3, d);
    chk("R7 non-pin control reads 0", d, 8'h00);
    raw_irq[3] = 1'b0; cyc(3);
    chk("R7 non-pin write ignored", flag[3], 0);
    raw_irq[3] = 1'b1; cyc(3);
    chk("R7 non-pin still rising", flag[3], 1);
    wr_reg(1'b0, 3, 8'h00);
  endtask

  task automatic t_collision();
    raw_irq[7] = 1'b0; cyc(3);
    raw_irq[7] = 1'b1; cyc(2);
    ack_valid = 1'b1; ack_id = AW'(7);
    cyc(1);
    ack_valid = 1'b0;
    chk("R8 event beats ack", flag[7], 1);
    raw_irq[7] = 1'b0; cyc(3);
    raw_irq[7] = 1'b1; cyc(2);
    wr_reg(1'b0, 7, 8'h00);
    chk("R8 event beats write", flag[7], 1);
    ack(7);
    chk("R8 later ack clears", flag[7], 0);
  endtask

  initial begin
    cyc(2);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_rise();
    t_read_and_clear();
    t_level();
    t_ack();
    t_pin_modes();
    t_collision();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule